// File: doc/BRIEF.md
# Standby Power-Mode Sequencer

This block decides when a small microcontroller-style system drops into its deepest software-initiated low-power state and how it gets back out. The CPU issues a sleep request. If the standby-select control bit is set, the sequencer turns off the oscillator enable and every clock enable. A second control bit, sampled at the moment of entry, decides whether the address bus and bus-control outputs float or hold their last values. A sleep request made while the select bit is clear does nothing here.

Standby ends in one of three ways:
- **Interrupt wake.** The non-maskable interrupt, or one of the external interrupt lines, wakes the block. Each external line must be enabled, unmasked at the CPU, and not routed to the transfer controller. On a wake the oscillator restarts first. Clocks return only after a settling countdown whose length comes from a 3-bit code. The wake is then reported with the highest-priority latched source.
- **Reset pin.** Pulling the reset pin low brings the clocks back at once. Releasing it signals a reset exception.
- **Hardware-standby pin.** Pulling this pin low forces hardware standby from any state. Only a reset with that pin high leaves it.

Top module: `stby_power_seq`

## Requirements
- R1: After the power-on reset `por_n` is released, the outputs are `osc_en`=1, `clk_en`=1, `bus_hiz`=0, `hw_stby`=0, `wake_req`=0 and `reset_exc`=0.
- R2: In the running state, a `sleep_req` with `stby_sel`=1 clears `osc_en` and `clk_en` in the next cycle. With `stby_sel`=0 the request is ignored and both stay 1.
- R3: In standby and while settling, `bus_hiz` equals the `bus_float_sel` value sampled in the entry cycle. Later changes of that input have no effect. `bus_hiz` is 0 in the running and reset-hold states.
- R4: `nmi` always qualifies as a wake source. `irq[i]` qualifies only when `irq_en[i]`=1, `irq_cpu_mask[i]`=0 and `irq_dma_route[i]`=0. An unqualified line leaves the block in standby with both enables at 0.
- R5: In the cycle after a qualified wake, `osc_en`=1 and `clk_en`=0. The `clk_en` output returns after exactly N reference ticks, counted while settling. N is (8192, 16384, 32768, 65536, 131072, 262144, 512, 1024) for `settle_code` 0 to 7, shifted right by `SETTLE_SHIFT`. The code is sampled in the wake cycle.
- R6: `wake_req` is a one-cycle pulse in the first cycle with `clk_en` back. During that pulse, `wake_pend` holds every source qualified in the wake cycle (bit 0 NMI, bit 1+i `irq[i]`). `wake_src` gives the highest-priority source: 0 NMI, 1 IRQ0, 2 IRQ1, 3 IRQ2.
- R7: `rst_pin_n` low with `hwstby_n` high gives `osc_en`=1, `clk_en`=1 and `bus_hiz`=0 in the next cycle, from any state and with no settling wait.
- R8: When `rst_pin_n` rises in reset hold, `reset_exc` pulses for exactly the first following cycle.
- R9: `hwstby_n` low gives `hw_stby`=1, `osc_en`=0, `clk_en`=0 and `bus_hiz`=1 in the next cycle, from any state. It overrides the reset pin and all wake sources.
- R10: Hardware standby is left only when `rst_pin_n` is low while `hwstby_n` is high, which leads to reset hold. Sleep requests and interrupts do nothing there.
- R11: Sources that arrive while settling are not latched and produce no extra wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ref_tick | input | 1 | Free-running reference tick for the settling count |
| sleep_req | input | 1 | Sleep request from the CPU |
| stby_sel | input | 1 | Selects software standby on sleep |
| bus_float_sel | input | 1 | 1: bus floats in standby; 0: bus holds its state |
| settle_code | input | 3 | Settling-time code |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | NUM_IRQ | External interrupt lines |
| irq_en | input | NUM_IRQ | Per-line enable |
| irq_cpu_mask | input | NUM_IRQ | Per-line mask applied at the CPU |
| irq_dma_route | input | NUM_IRQ | Line is routed to the transfer controller |
| rst_pin_n | input | 1 | Reset pin, active low |
| hwstby_n | input | 1 | Hardware-standby pin, active low |
| osc_en | output | 1 | Oscillator enable |
| clk_en | output | 1 | System clock enable |
| bus_hiz | output | 1 | Bus and bus-control outputs high-impedance |
| hw_stby | output | 1 | Hardware standby active |
| wake_req | output | 1 | Interrupt-handling request pulse |
| wake_src | output | 2 | Highest-priority latched wake source |
| wake_pend | output | NUM_IRQ+1 | All latched wake sources |
| reset_exc | output | 1 | Reset-exception pulse |

## Verification
The outputs are decoded directly from the state, so a wrong next-state choice shows on `osc_en`, `clk_en`, `bus_hiz` or `hw_stby` in the very next cycle. The bench compares every cycle against its own model, so such a mismatch is caught at once. A countdown that loads the wrong length, or decrements without a tick, shows up only when `clk_en` comes back. That can be as much as several thousand cycles later, and it is caught by measuring the settling length for every code. A wrong source latch or priority shows only during the one-cycle `wake_req` pulse, so `wake_pend` and `wake_src` are checked in exactly that cycle.

// File: rtl/stby_pkg.sv
package stby_pkg;
   typedef enum logic [2:0] {
      PM_RUN     = 3'd0,
      PM_SWSTBY  = 3'd1,
      PM_SETTLE  = 3'd2,
      PM_RSTHOLD = 3'd3,
      PM_HWSTBY  = 3'd4
   } pm_state_t;

   localparam int SETTLE_CODE_W = 3;
   localparam int SETTLE_FULL_W = 19;
endpackage

// File: rtl/stby_wake_qual.sv
module stby_wake_qual #(
   parameter int NUM_IRQ = 3
) (
   input  logic               nmi,
   input  logic [NUM_IRQ-1:0] irq,
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic [NUM_IRQ-1:0] irq_mask,
   input  logic [NUM_IRQ-1:0] irq_route,
   output logic [NUM_IRQ:0]   hit,
   output logic               any_hit
);
   assign hit[0] = nmi;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      assign hit[i+1] = irq[i] & irq_en[i] & ~irq_mask[i] & ~irq_route[i];
   end

   assign any_hit = |hit;
endmodule

// File: rtl/stby_wake_prio.sv
module stby_wake_prio #(
   parameter int NUM_SRC = 4,
   parameter int SRC_W   = 2
) (
   input  logic [NUM_SRC-1:0] pend,
   output logic [SRC_W-1:0]   src
);
   always_comb begin
      src = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend[i]) src = SRC_W'(i);
      end
   end
endmodule

// File: rtl/stby_settle_timer.sv
module stby_settle_timer
   import stby_pkg::*;
#(
   parameter int SHIFT = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [SETTLE_CODE_W-1:0] code,
   input  logic                     active,
   input  logic                     tick,
   output logic                     done
);
   localparam int CNT_W = SETTLE_FULL_W - SHIFT;

   logic [CNT_W-1:0] cnt;

   function automatic logic [CNT_W-1:0] span(input logic [SETTLE_CODE_W-1:0] c);
      logic [SETTLE_FULL_W-1:0] full;
      if (c < 3'd6) full = SETTLE_FULL_W'(1) << (13 + int'(c));
      else          full = SETTLE_FULL_W'(1) << (3 + int'(c));
      return CNT_W'(full >> SHIFT);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt <= '0;
      else if (load)                         cnt <= span(code);
      else if (active && tick && cnt > CNT_W'(1)) cnt <= cnt - 1'b1;
   end

   assign done = active & tick & (cnt == CNT_W'(1));

   assert_span_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt != '0));
   assert_span_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !tick && !load) |=> $stable(cnt));
endmodule

// File: rtl/stby_power_seq.sv
module stby_power_seq
   import stby_pkg::*;
#(
   parameter int NUM_IRQ      = 3,
   parameter int SETTLE_SHIFT = 0,
   localparam int NUM_SRC     = NUM_IRQ + 1,
   localparam int SRC_W       = $clog2(NUM_SRC)
) (
   input  logic                     clk,
   input  logic                     por_n,
   input  logic                     ref_tick,
   input  logic                     sleep_req,
   input  logic                     stby_sel,
   input  logic                     bus_float_sel,
   input  logic [SETTLE_CODE_W-1:0] settle_code,
   input  logic                     nmi,
   input  logic [NUM_IRQ-1:0]       irq,
   input  logic [NUM_IRQ-1:0]       irq_en,
   input  logic [NUM_IRQ-1:0]       irq_cpu_mask,
   input  logic [NUM_IRQ-1:0]       irq_dma_route,
   input  logic                     rst_pin_n,
   input  logic                     hwstby_n,
   output logic                     osc_en,
   output logic                     clk_en,
   output logic                     bus_hiz,
   output logic                     hw_stby,
   output logic                     wake_req,
   output logic [SRC_W-1:0]         wake_src,
   output logic [NUM_SRC-1:0]       wake_pend,
   output logic                     reset_exc
);
   initial begin : elab_checks
      assert (NUM_IRQ >= 1 && NUM_IRQ <= 7)
         else $error("NUM_IRQ out of range");
      assert (SETTLE_SHIFT >= 0 && SETTLE_SHIFT <= 9)
         else $error("SETTLE_SHIFT out of range");
   end

   pm_state_t          state_q, state_d;
   logic [NUM_SRC-1:0] hit;
   logic               any_hit;
   logic               settle_done;
   logic               load;
   logic               hiz_q;
   logic [NUM_SRC-1:0] pend_q;
   logic               wake_q;
   logic               rexc_q;

   stby_wake_qual #(.NUM_IRQ(NUM_IRQ)) u_qual (
      .nmi       (nmi),
      .irq       (irq),
      .irq_en    (irq_en),
      .irq_mask  (irq_cpu_mask),
      .irq_route (irq_dma_route),
      .hit       (hit),
      .any_hit   (any_hit)
   );

   stby_settle_timer #(.SHIFT(SETTLE_SHIFT)) u_timer (
      .clk    (clk),
      .rst_n  (por_n),
      .load   (load),
      .code   (settle_code),
      .active (state_q == PM_SETTLE),
      .tick   (ref_tick),
      .done   (settle_done)
   );

   stby_wake_prio #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_prio (
      .pend (pend_q),
      .src  (wake_src)
   );

   always_comb begin
      state_d = state_q;
      if (!hwstby_n) begin
         state_d = PM_HWSTBY;
      end else begin
         case (state_q)
            PM_HWSTBY:  if (!rst_pin_n) state_d = PM_RSTHOLD;
            PM_RSTHOLD: if (rst_pin_n)  state_d = PM_RUN;
            PM_RUN: begin
               if (!rst_pin_n)                  state_d = PM_RSTHOLD;
               else if (sleep_req && stby_sel) state_d = PM_SWSTBY;
            end
            PM_SWSTBY: begin
               if (!rst_pin_n)   state_d = PM_RSTHOLD;
               else if (any_hit) state_d = PM_SETTLE;
            end
            PM_SETTLE: begin
               if (!rst_pin_n)       state_d = PM_RSTHOLD;
               else if (settle_done) state_d = PM_RUN;
            end
            default: state_d = PM_RUN;
         endcase
      end
   end

   assign load = (state_q == PM_SWSTBY) && (state_d == PM_SETTLE);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q <= PM_RUN;
         hiz_q   <= 1'b0;
         pend_q  <= '0;
         wake_q  <= 1'b0;
         rexc_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == PM_RUN && state_d == PM_SWSTBY) hiz_q <= bus_float_sel;
         if (load) pend_q <= hit;
         wake_q <= (state_q == PM_SETTLE)  && (state_d == PM_RUN);
         rexc_q <= (state_q == PM_RSTHOLD) && (state_d == PM_RUN);
      end
   end

   always_comb begin
      osc_en  = 1'b1;
      clk_en  = 1'b1;
      bus_hiz = 1'b0;
      hw_stby = 1'b0;
      case (state_q)
         PM_SWSTBY: begin osc_en = 1'b0; clk_en = 1'b0; bus_hiz = hiz_q; end
         PM_SETTLE: begin clk_en = 1'b0; bus_hiz = hiz_q; end
         PM_HWSTBY: begin
            osc_en = 1'b0; clk_en = 1'b0; bus_hiz = 1'b1; hw_stby = 1'b1;
         end
         default: ;
      endcase
   end

   assign wake_req  = wake_q;
   assign reset_exc = rexc_q;
   assign wake_pend = pend_q;

   // R2: entry and ignore paths
   assert_stby_entry_R2: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == PM_RUN && sleep_req && stby_sel && hwstby_n && rst_pin_n)
      |=> (!osc_en && !clk_en));
   assert_sleep_ignored_R2: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == PM_RUN && sleep_req && !stby_sel && hwstby_n && rst_pin_n)
      |=> (osc_en && clk_en));
   // R3: bus mode captured at entry
   assert_bus_mode_R3: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == PM_RUN && sleep_req && stby_sel && hwstby_n && rst_pin_n)
      |=> (bus_hiz == $past(bus_float_sel)));
   // R4: blocked lines keep standby
   assert_blocked_stays_R4: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == PM_SWSTBY && !nmi && hwstby_n && rst_pin_n &&
       ((irq & irq_en & ~irq_cpu_mask & ~irq_dma_route) == '0))
      |=> (!osc_en && !clk_en));
   // R5: oscillator first, clocks later
   assert_osc_first_R5: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == PM_SWSTBY && nmi && hwstby_n && rst_pin_n)
      |=> (osc_en && !clk_en));
   // R6: wake pulse shape and source
   assert_wake_pulse_R6: assert property (@(posedge clk) disable iff (!por_n)
      wake_req |=> !wake_req);
   assert_wake_src_R6: assert property (@(posedge clk) disable iff (!por_n)
      wake_req |-> (wake_pend[wake_src] && clk_en));
   // R7: reset brings clocks back at once
   assert_reset_fast_R7: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_pin_n && hwstby_n) |=> (osc_en && clk_en && !bus_hiz));
   // R8: reset exception follows reset hold
   assert_reset_exc_R8: assert property (@(posedge clk) disable iff (!por_n)
      reset_exc |-> ($past(state_q) == PM_RSTHOLD));
   // R9: hardware standby overrides everything
   assert_hw_force_R9: assert property (@(posedge clk) disable iff (!por_n)
      !hwstby_n |=> (hw_stby && !osc_en && !clk_en && bus_hiz));
   // R10: only a reset leaves hardware standby
   assert_hw_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
      (hw_stby && hwstby_n && rst_pin_n) |=> hw_stby);
   // R11: no wake pulse while still settling
   assert_settle_quiet_R11: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == PM_SETTLE) |-> !wake_req);
endmodule

// File: tb/stby_power_seq_test.sv
`timescale 1ns/1ps
module stby_power_seq_test;
   localparam int SHIFT = 6;
   localparam int S_RUN = 0, S_SW = 1, S_SET = 2, S_RST = 3, S_HW = 4;

   logic       clk = 1'b0;
   logic       por_n, ref_tick, sleep_req, stby_sel, bus_float_sel;
   logic [2:0] settle_code;
   logic       nmi;
   logic [2:0] irq, irq_en, irq_cpu_mask, irq_dma_route;
   logic       rst_pin_n, hwstby_n;
   logic       osc_en, clk_en, bus_hiz, hw_stby, wake_req, reset_exc;
   logic [1:0] wake_src;
   logic [3:0] wake_pend;

   int total = 0, bad = 0, cyc = 0;
   bit cmp_on = 0, finished = 0;
   int m_st, m_cnt, m_hiz, m_pend, m_wake, m_rexc, q, n;

   always #4 clk = ~clk;

   stby_power_seq #(.NUM_IRQ(3), .SETTLE_SHIFT(SHIFT)) uut (
      .clk(clk), .por_n(por_n), .ref_tick(ref_tick), .sleep_req(sleep_req),
      .stby_sel(stby_sel), .bus_float_sel(bus_float_sel),
      .settle_code(settle_code), .nmi(nmi), .irq(irq), .irq_en(irq_en),
      .irq_cpu_mask(irq_cpu_mask), .irq_dma_route(irq_dma_route),
      .rst_pin_n(rst_pin_n), .hwstby_n(hwstby_n), .osc_en(osc_en),
      .clk_en(clk_en), .bus_hiz(bus_hiz), .hw_stby(hw_stby),
      .wake_req(wake_req), .wake_src(wake_src), .wake_pend(wake_pend),
      .reset_exc(reset_exc));

   function automatic int exp_len(input int c);
      if (c < 6) return (1 << (13 + c)) >> SHIFT;
      return (1 << (3 + c)) >> SHIFT;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // behavioural reference model
   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_st = S_RUN; m_cnt = 0; m_hiz = 0; m_pend = 0; m_wake = 0; m_rexc = 0;
      end else begin
         q = nmi ? 1 : 0;
         for (int i = 0; i < 3; i++)
            if (irq[i] && irq_en[i] && !irq_cpu_mask[i] && !irq_dma_route[i]) q += (2 << i);
         m_wake = 0; m_rexc = 0;
         if (!hwstby_n) m_st = S_HW;
         else if (m_st == S_HW) begin if (!rst_pin_n) m_st = S_RST; end
         else if (m_st == S_RST) begin
            if (rst_pin_n) begin m_st = S_RUN; m_rexc = 1; end
         end
         else if (!rst_pin_n) m_st = S_RST;
         else if (m_st == S_RUN) begin
            if (sleep_req && stby_sel) begin m_st = S_SW; m_hiz = bus_float_sel; end
         end
         else if (m_st == S_SW) begin
            if (q != 0) begin m_st = S_SET; m_pend = q; m_cnt = exp_len(settle_code); end
         end
         else if (ref_tick) begin
            if (m_cnt == 1) begin m_st = S_RUN; m_wake = 1; end
            else m_cnt--;
         end
      end
   end

   function automatic string tag_of(input int s);
      case (s)
         S_SET:   return "R5";
         S_RST:   return "R7";
         S_HW:    return "R9";
         default: return "R2";
      endcase
   endfunction

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (por_n && cmp_on) begin
         chk({tag_of(m_st), " osc_en"}, osc_en, (m_st == S_RUN || m_st == S_SET || m_st == S_RST));
         chk({tag_of(m_st), " clk_en"}, clk_en, (m_st == S_RUN || m_st == S_RST));
         chk("R3 bus_hiz", bus_hiz, (m_st == S_HW) ? 1 : ((m_st == S_SW || m_st == S_SET) ? m_hiz : 0));
         chk("R9 hw_stby", hw_stby, (m_st == S_HW));
         chk("R6 wake_req", wake_req, m_wake);
         chk("R8 reset_exc", reset_exc, m_rexc);
         if (m_wake) begin
            chk("R6 wake_pend", wake_pend, m_pend);
            chk("R6 wake_src", wake_src,
                m_pend[0] ? 0 : m_pend[1] ? 1 : m_pend[2] ? 2 : 3);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
         finish_run();
      end
   end

   task automatic go_standby(input logic h);
      stby_sel = 1; bus_float_sel = h; sleep_req = 1;
      @(negedge clk);
      sleep_req = 0; bus_float_sel = ~h;
   endtask

   task automatic wait_wake();
      n = 0;
      while (!clk_en && n < 10000) begin n++; @(negedge clk); end
   endtask

   initial begin
      por_n = 0; ref_tick = 1; sleep_req = 0; stby_sel = 0; bus_float_sel = 0;
      settle_code = 0; nmi = 0; irq = 0; irq_en = 0; irq_cpu_mask = 0;
      irq_dma_route = 0; rst_pin_n = 1; hwstby_n = 1;
      repeat (3) @(negedge clk);
      por_n = 1; cmp_on = 1;
      @(negedge clk);
      chk("R1 osc_en", osc_en, 1);   chk("R1 clk_en", clk_en, 1);
      chk("R1 bus_hiz", bus_hiz, 0); chk("R1 hw_stby", hw_stby, 0);
      chk("R1 wake_req", wake_req, 0); chk("R1 reset_exc", reset_exc, 0);

      // R2: sleep without standby select is ignored
      stby_sel = 0; sleep_req = 1; @(negedge clk); sleep_req = 0;
      chk("R2 ignored clk_en", clk_en, 1); chk("R2 ignored osc_en", osc_en, 1);

      // R5/R6/R3: every settling code, NMI wake
      for (int c = 0; c < 8; c++) begin
         settle_code = 3'(c);
         go_standby(c[0]);
         chk("R2 osc off", osc_en, 0);
         chk("R3 bus mode sampled", bus_hiz, c[0]);
         nmi = 1; @(negedge clk); nmi = 0; settle_code = 3'(7 - c);
         chk("R5 osc first", osc_en, 1); chk("R5 clk held", clk_en, 0);
         wait_wake();
         chk("R5 settle length", n, exp_len(c));
         chk("R6 wake pulse", wake_req, 1); chk("R6 nmi src", wake_src, 0);
         @(negedge clk); chk("R6 single pulse", wake_req, 0);
      end

      // R4: gating per line
      settle_code = 6;
      for (int i = 0; i < 3; i++) begin
         go_standby(0);
         irq[i] = 1; irq_en = 0; repeat (3) @(negedge clk);
         chk("R4 disabled line", osc_en | clk_en, 0);
         irq_en[i] = 1; irq_cpu_mask[i] = 1; repeat (3) @(negedge clk);
         chk("R4 cpu-masked line", osc_en | clk_en, 0);
         irq_cpu_mask[i] = 0; irq_dma_route[i] = 1; repeat (3) @(negedge clk);
         chk("R4 dma-routed line", osc_en | clk_en, 0);
         irq_dma_route[i] = 0; @(negedge clk); irq = 0;
         chk("R4 qualified line wakes", osc_en, 1);
         wait_wake();
         chk("R6 irq src", wake_src, i + 1); chk("R6 irq pend", wake_pend, 2 << i);
         irq_en = 0;
      end

      // R6: simultaneous sources
      irq_en = 3'b111;
      go_standby(1); nmi = 1; irq = 3'b010; @(negedge clk); nmi = 0; irq = 0;
      wait_wake();
      chk("R6 both latched", wake_pend, 4'b0101); chk("R6 nmi wins", wake_src, 0);
      go_standby(0); irq = 3'b101; @(negedge clk); irq = 0;
      wait_wake();
      chk("R6 two irqs latched", wake_pend, 4'b1010); chk("R6 irq0 wins", wake_src, 1);

      // R11: sources during settling ignored
      go_standby(0); irq = 3'b100; @(negedge clk); irq = 0;
      @(negedge clk); nmi = 1; irq = 3'b001; @(negedge clk); nmi = 0; irq = 0;
      wait_wake();
      chk("R11 late source not latched", wake_pend, 4'b1000);
      chk("R11 src", wake_src, 3);
      repeat (20) @(negedge clk);
      chk("R11 no second pulse", wake_req, 0);

      // ticks on every other cycle
      settle_code = 7; go_standby(0); nmi = 1; @(negedge clk); nmi = 0;
      n = 0;
      while (!clk_en && n < 1000) begin ref_tick = ~ref_tick; n++; @(negedge clk); end
      ref_tick = 1;
      chk("R5 only ticks counted", n, 32);

      // R7/R8: reset from standby and from settling
      go_standby(1); rst_pin_n = 0; @(negedge clk);
      chk("R7 osc_en", osc_en, 1); chk("R7 clk_en", clk_en, 1); chk("R7 bus_hiz", bus_hiz, 0);
      repeat (3) @(negedge clk); chk("R8 no early exc", reset_exc, 0);
      rst_pin_n = 1; @(negedge clk); chk("R8 exc pulse", reset_exc, 1);
      @(negedge clk); chk("R8 exc single", reset_exc, 0);
      settle_code = 0; go_standby(0); nmi = 1; @(negedge clk); nmi = 0;
      repeat (5) @(negedge clk); rst_pin_n = 0; @(negedge clk);
      chk("R7 no settle wait", clk_en, 1);
      rst_pin_n = 1; @(negedge clk); chk("R8 exc after settle abort", reset_exc, 1);

      // R9/R10: hardware standby
      hwstby_n = 0; @(negedge clk);
      chk("R9 hw_stby", hw_stby, 1); chk("R9 osc off", osc_en, 0); chk("R9 bus float", bus_hiz, 1);
      rst_pin_n = 0; @(negedge clk); chk("R9 overrides reset", hw_stby, 1);
      rst_pin_n = 1; hwstby_n = 1; nmi = 1; irq = 3'b111; sleep_req = 1;
      repeat (3) @(negedge clk);
      chk("R10 wake ignored", hw_stby, 1); chk("R10 clocks stay off", clk_en, 0);
      nmi = 0; irq = 0; sleep_req = 0;
      rst_pin_n = 0; @(negedge clk);
      chk("R10 reset exits", hw_stby, 0); chk("R10 clocks back", clk_en, 1);
      rst_pin_n = 1; @(negedge clk); chk("R8 exc after hw", reset_exc, 1);
      settle_code = 1; go_standby(0); nmi = 1; @(negedge clk); nmi = 0;
      repeat (4) @(negedge clk); hwstby_n = 0; @(negedge clk);
      chk("R9 from settling", hw_stby, 1);
      hwstby_n = 1; rst_pin_n = 0; @(negedge clk); rst_pin_n = 1;
      repeat (3) @(negedge clk);
      chk("R10 back to run", clk_en, 1);

      finish_run();
   end
endmodule